// File: doc/BRIEF.md
# Two-Channel DMA Engine with Global Halt and Resume

The engine moves 32-bit words from a source address to a destination address on behalf of two channels. Each word is one transfer: a read beat followed by a write beat on a single-beat memory port. Before its first beat the engine requests the system bus and waits for a grant. A channel is served on an external request, which is a one-cycle pulse latched for the rest of the block. It can instead be served on an internal peripheral request, which is a level qualified by that peripheral's request-enable. Channel 0 always wins over channel 1, and arbitration takes place only between transfers.

A global register holds a master enable and a non-maskable-interrupt flag. The flag is set by a pulse on `nmi_in`. When the flag is set, or the master enable is cleared, every channel stops at the next transfer boundary and the bus is released. The address and count registers are left pointing at the transfer that would have come next, and no channel's completion flag is raised. Clearing the flag needs a read that returns 1 followed by a write of 0. While the flag is set, external and internal requests lose their effect, so software must re-arm them before work resumes. Restoring the master enable instead resumes the block from the next transfer without any new request.

The sequencer has four states. In IDLE nothing is requested. In BUSREQ the bus is requested and the engine waits for the grant. In READ the source beat is in progress, and in WRITE the destination beat is in progress. The transitions are:
- **start** (IDLE to BUSREQ): the engine is running and some channel is eligible.
- **abandon** (BUSREQ to IDLE): a halt condition is seen before the grant.
- **granted** (BUSREQ to READ).
- **read_done** (READ to WRITE): the read beat is acknowledged.
- **boundary** (WRITE to IDLE): the write beat is acknowledged and the channel's registers step.

Top module: `dxfer_engine`

## Requirements
- R1: After reset, all channel registers, the global register, `bus_req` and `mem_req` are 0.
- R2: A transfer asserts `bus_req`, waits for `bus_gnt`, then reads from the channel source address and writes the word read to the channel destination address. Once the write is acknowledged, source and destination each advance by 4 and the count drops by 1.
- R3: When a channel's count reaches 0 through a transfer, its done flag (control bit 1) is set. While done is set the channel makes no transfer. Writing 0 to control bit 1 clears the flag, and writing 1 to it has no effect.
- R4: When both channels are eligible, channel 0 is served first. Arbitration happens only in IDLE.
- R5: A pulse on `nmi_in` sets the NMI flag (global bit 1). All channels stop at the next transfer boundary and `bus_req` drops. Source, destination and count then hold the next transfer's state, and no done flag is set.
- R6: The NMI flag clears only on a global-register write with bit 1 equal to 0, made after a global read that returned bit 1 set. A write of 0 without such a read leaves the flag set, and software writing 1 cannot set it.
- R7: While the NMI flag is set, latched external requests are discarded and new `ext_req` pulses are ignored. After the flag is cleared, a fresh pulse is needed.
- R8: While the NMI flag is set, internal requests are blocked. After the flag is cleared, a channel's internal request is honoured only once its `int_req_en` has been seen at 0 and then raised again.
- R9: Clearing the master enable (global bit 0) stops all channels at a transfer boundary with state kept and no done flag set. Setting it again resumes the block with no new request.
- R10: With control bit 2 at 0, a single `ext_req` pulse is latched and serves the whole block. With bit 2 at 1, the channel transfers while both `int_req` and `int_req_en` are high.
- R11: `reg_addr` is a word index. Channel i uses 4i+0 for source, 4i+1 for destination, 4i+2 for count and 4i+3 for control (bit 0 enable, bit 1 done, bit 2 source select). The global register is at index 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, used to arm the NMI clear |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| ext_req | input | 2 | External request pulses, one per channel |
| int_req | input | 2 | Internal peripheral request levels |
| int_req_en | input | 2 | Peripheral request-enable levels |
| nmi_in | input | 1 | Non-maskable interrupt pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data |
| mem_ack | input | 1 | Beat acknowledge |

## Verification
The bench sweeps block lengths 1 to 4 on both channels and checks every destination word, the final address and count values, and the order of the write beats. It raises the NMI pulse and the master-enable clear at the exact cycle a transfer ends. A design that let one more transfer slip through would leave the count one lower, and a design that set done on a halt would show it in the control register. The NMI clear is tried without the arming read, and requests are replayed during and after the flag. A design that kept stale requests would resume on its own, and one that never unblocked internal requests after the enable toggle would hang short of the block's end.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSREQ,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    localparam int REGS_PER_CH = 4;
    localparam int OFF_SRC     = 0;
    localparam int OFF_DST     = 1;
    localparam int OFF_CNT     = 2;
    localparam int OFF_CTL     = 3;

    localparam int CTL_EN      = 0;
    localparam int CTL_DONE    = 1;
    localparam int CTL_SEL     = 2;

    localparam int GLB_EN      = 0;
    localparam int GLB_NMI     = 1;

endpackage

// File: rtl/dxfer_gate.sv
module dxfer_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic glb_wr,
    input  logic glb_rd,
    input  logic wbit_en,
    input  logic wbit_nmi,
    output logic gen_en,
    output logic nmi_flag,
    output logic run_ok
);
    // Set when a global read returned the NMI flag as 1; consumed by any global write.
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en   <= 1'b0;
            nmi_flag <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            if (glb_wr) begin
                gen_en <= wbit_en;
            end
            if (nmi_in) begin
                nmi_flag <= 1'b1;
            end else if (glb_wr && armed_q && !wbit_nmi) begin
                nmi_flag <= 1'b0;
            end
            if (glb_wr) begin
                armed_q <= 1'b0;
            end else if (glb_rd && nmi_flag) begin
                armed_q <= 1'b1;
            end
        end
    end

    assign run_ok = gen_en && !nmi_flag;

endmodule

// File: rtl/dxfer_chan.sv
module dxfer_chan #(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_src,
    input  logic          wr_dst,
    input  logic          wr_cnt,
    input  logic          wr_ctl,
    input  logic [AW-1:0] wd_addr,
    input  logic [CW-1:0] wd_cnt,
    input  logic [2:0]    wd_ctl,
    input  logic          step,
    input  logic          nmi_flag,
    input  logic          ext_req,
    input  logic          int_req,
    input  logic          int_req_en,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic          en_q,
    output logic          done_q,
    output logic          sel_q,
    output logic          eligible
);
    import dxfer_pkg::*;

    logic pend_q;
    logic blk_q;
    logic last_beat;
    logic req_ok;

    assign last_beat = step && (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            src_q <= src_q + AW'(STEP);
            dst_q <= dst_q + AW'(STEP);
            cnt_q <= cnt_q - CW'(1);
        end else begin
            if (wr_src) src_q <= wd_addr;
            if (wr_dst) dst_q <= wd_addr;
            if (wr_cnt) cnt_q <= wd_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sel_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                en_q  <= wd_ctl[CTL_EN];
                sel_q <= wd_ctl[CTL_SEL];
            end
            if (last_beat) begin
                done_q <= 1'b1;
            end else if (wr_ctl && !wd_ctl[CTL_DONE]) begin
                done_q <= 1'b0;
            end
        end
    end

    // External pulse latch: lives for the block, lost on NMI.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (nmi_flag) begin
            pend_q <= 1'b0;
        end else if (ext_req) begin
            pend_q <= 1'b1;
        end else if (last_beat) begin
            pend_q <= 1'b0;
        end
    end

    // Internal-request block: raised by NMI, lowered once the peripheral enable is seen low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (nmi_flag) begin
            blk_q <= 1'b1;
        end else if (!int_req_en) begin
            blk_q <= 1'b0;
        end
    end

    assign req_ok   = sel_q ? (int_req && int_req_en && !blk_q) : pend_q;
    assign eligible = en_q && !done_q && (cnt_q != '0) && req_ok;

endmodule

// File: rtl/dxfer_arb.sv
module dxfer_arb #(
    parameter int NCH = 2,
    parameter int IW  = 1
) (
    input  logic [NCH-1:0] elig,
    output logic           any,
    output logic [IW-1:0]  pick
);
    always_comb begin
        any  = |elig;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dxfer_seq.sv
module dxfer_seq #(
    parameter int IW = 1,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  logic          any,
    input  logic [IW-1:0] pick,
    input  logic          bus_gnt,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [IW-1:0] cur,
    output logic          bus_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] wbuf,
    output logic          step
);
    import dxfer_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_ok && any) state_d = ST_BUSREQ;       // start
            end
            ST_BUSREQ: begin
                if (!run_ok)      state_d = ST_IDLE;          // abandon
                else if (bus_gnt) state_d = ST_READ;          // granted
            end
            ST_READ: begin
                if (mem_ack) state_d = ST_WRITE;              // read_done
            end
            ST_WRITE: begin
                if (mem_ack) state_d = ST_IDLE;               // boundary
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= '0;
            wbuf <= '0;
        end else begin
            if (state_q == ST_IDLE && run_ok && any) cur <= pick;
            if (state_q == ST_READ && mem_ack)        wbuf <= mem_rdata;
        end
    end

    always_comb begin
        bus_req = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSREQ: begin
                bus_req = 1'b1;
            end
            ST_READ: begin
                bus_req = 1'b1;
                mem_req = 1'b1;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = mem_ack;
            end
        endcase
    end

endmodule

// File: rtl/dxfer_engine.sv
module dxfer_engine
    import dxfer_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4,
    parameter int RW   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [$clog2(NCH*4+1)-1:0]   reg_addr,
    input  logic [RW-1:0]                reg_wdata,
    output logic [RW-1:0]                reg_rdata,
    input  logic [NCH-1:0]               ext_req,
    input  logic [NCH-1:0]               int_req,
    input  logic [NCH-1:0]               int_req_en,
    input  logic                         nmi_in,
    output logic                         bus_req,
    input  logic                         bus_gnt,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_wdata,
    input  logic [DW-1:0]                mem_rdata,
    input  logic                         mem_ack
);
    localparam int RAW     = $clog2(NCH * REGS_PER_CH + 1);
    localparam int CIW     = RAW - 2;
    localparam int IW      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int GLB_IDX = NCH * REGS_PER_CH;

    logic          gen_en;
    logic          nmi_flag;
    logic          run_ok;
    logic          glb_wr;
    logic          glb_rd;
    logic          any;
    logic [IW-1:0] pick;
    logic [IW-1:0] cur;
    logic          seq_step;
    logic [DW-1:0] wbuf;

    logic [NCH-1:0] elig;
    logic [NCH-1:0] en_vec;
    logic [NCH-1:0] done_vec;
    logic [NCH-1:0] sel_vec;
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];

    assign glb_wr = reg_wr && (reg_addr == RAW'(GLB_IDX));
    assign glb_rd = reg_rd && (reg_addr == RAW'(GLB_IDX));

    dxfer_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_in   (nmi_in),
        .glb_wr   (glb_wr),
        .glb_rd   (glb_rd),
        .wbit_en  (reg_wdata[GLB_EN]),
        .wbit_nmi (reg_wdata[GLB_NMI]),
        .gen_en   (gen_en),
        .nmi_flag (nmi_flag),
        .run_ok   (run_ok)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = reg_wr && (reg_addr[RAW-1:2] == CIW'(g));

        dxfer_chan #(
            .AW   (AW),
            .CW   (CW),
            .STEP (STEP)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_src     (hit && (reg_addr[1:0] == 2'(OFF_SRC))),
            .wr_dst     (hit && (reg_addr[1:0] == 2'(OFF_DST))),
            .wr_cnt     (hit && (reg_addr[1:0] == 2'(OFF_CNT))),
            .wr_ctl     (hit && (reg_addr[1:0] == 2'(OFF_CTL))),
            .wd_addr    (reg_wdata[AW-1:0]),
            .wd_cnt     (reg_wdata[CW-1:0]),
            .wd_ctl     (reg_wdata[2:0]),
            .step       (seq_step && (cur == IW'(g))),
            .nmi_flag   (nmi_flag),
            .ext_req    (ext_req[g]),
            .int_req    (int_req[g]),
            .int_req_en (int_req_en[g]),
            .src_q      (src_a[g]),
            .dst_q      (dst_a[g]),
            .cnt_q      (cnt_a[g]),
            .en_q       (en_vec[g]),
            .done_q     (done_vec[g]),
            .sel_q      (sel_vec[g]),
            .eligible   (elig[g])
        );
    end

    dxfer_arb #(
        .NCH (NCH),
        .IW  (IW)
    ) u_arb (
        .elig (elig),
        .any  (any),
        .pick (pick)
    );

    dxfer_seq #(
        .IW (IW),
        .DW (DW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (run_ok),
        .any       (any),
        .pick      (pick),
        .bus_gnt   (bus_gnt),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .cur       (cur),
        .bus_req   (bus_req),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .wbuf      (wbuf),
        .step      (seq_step)
    );

    assign mem_addr  = mem_we ? dst_a[cur] : src_a[cur];
    assign mem_wdata = wbuf;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RAW'(GLB_IDX)) begin
            reg_rdata = RW'({nmi_flag, gen_en});
        end
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr[RAW-1:2] == CIW'(i)) begin
                case (reg_addr[1:0])
                    2'(OFF_SRC): reg_rdata = RW'(src_a[i]);
                    2'(OFF_DST): reg_rdata = RW'(dst_a[i]);
                    2'(OFF_CNT): reg_rdata = RW'(cnt_a[i]);
                    default:     reg_rdata = RW'({sel_vec[i], done_vec[i], en_vec[i]});
                endcase
            end
        end
    end

endmodule

// File: rtl/dxfer_engine_chk.sv
module dxfer_engine_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic           gen_en,
    input logic           nmi_flag,
    input logic           glb_clr_try,
    input logic [NCH-1:0] done_vec
);

    AST_BEAT_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_req); // R2

    AST_GRANT_BEFORE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(bus_gnt)); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R2

    AST_DONE_AT_WRITE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_vec & ~$past(done_vec))) |-> $past(mem_req && mem_we && mem_ack)); // R3

    AST_HALT_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !mem_req && !(gen_en && !nmi_flag)) |=> !bus_req); // R5

    AST_NO_START_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(gen_en && !nmi_flag)); // R9

    AST_NMI_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_flag) |-> $past(glb_clr_try)); // R6

endmodule

bind dxfer_engine dxfer_engine_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .gen_en      (gen_en),
    .nmi_flag    (nmi_flag),
    .glb_clr_try (glb_wr && !reg_wdata[1]),
    .done_vec    (done_vec)
);

// File: tb/dxfer_engine_test.sv
`timescale 1ns/1ps
module dxfer_engine_test;

    localparam int GLB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ext_req = '0;
    logic [1:0]  int_req = '0;
    logic [1:0]  int_req_en = '0;
    logic        nmi_in = 1'b0;
    logic        bus_req;
    logic        bus_gnt;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    logic [31:0] mem  [128];
    logic [31:0] wlog [128];
    int          wcnt;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    assign bus_gnt   = bus_req;
    assign mem_rdata = mem[mem_addr[8:2]];

    function automatic logic [31:0] pat(int w);
        return 32'hA500_0000 + 32'(w * 17 + 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
            for (int i = 0; i < 128; i++) mem[i] <= (i < 32) ? pat(i) : 32'h0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack && mem_we) begin
                mem[mem_addr[8:2]] <= mem_wdata;
                wlog[wcnt[6:0]]    <= mem_addr;
                wcnt               <= wcnt + 1;
            end
        end
    end

    dxfer_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ext_req    (ext_req),
        .int_req    (int_req),
        .int_req_en (int_req_en),
        .nmi_in     (nmi_in),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_addr  = 4'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = 4'(a);
        reg_rd   = 1'b1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_writes(int target);
        int n = 0;
        while (wcnt < target && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic setup(int ch, int s, int d, int n, int ctl);
        wr(ch * 4 + 0, 32'(s * 4));
        wr(ch * 4 + 1, 32'(d * 4));
        wr(ch * 4 + 2, 32'(n));
        wr(ch * 4 + 3, 32'(ctl));
    endtask

    task automatic pulse_ext(int ch);
        ext_req[ch] = 1'b1;
        @(negedge clk);
        ext_req = '0;
    endtask

    task automatic pulse_nmi();
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
    endtask

    task automatic verify_block(int ch, int s, int d, int n, string tag);
        logic [31:0] v;
        rd(ch * 4 + 2, v);
        chk(v == 0, {tag, " count at block end"}, v, 0);
        rd(ch * 4 + 3, v);
        chk(v[1] == 1'b1, {tag, " R3 done flag set"}, v, v | 32'h2);
        rd(ch * 4 + 0, v);
        chk(v == 32'((s + n) * 4), {tag, " R2 source final"}, v, 32'((s + n) * 4));
        rd(ch * 4 + 1, v);
        chk(v == 32'((d + n) * 4), {tag, " R2 destination final"}, v, 32'((d + n) * 4));
        for (int k = 0; k < n; k++) begin
            chk(mem[d + k] == pat(s + k), {tag, " R2 copied word"}, mem[d + k], pat(s + k));
        end
        chk(bus_req == 1'b0, {tag, " R2 bus released"}, 32'(bus_req), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int dptr;
        int base;
        int s;
        int d;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, R11 map
        for (int a = 0; a <= GLB; a++) begin
            rd(a, v);
            chk(v == 0, "R1 R11 register after reset", v, 0);
        end
        chk(bus_req == 1'b0, "R1 bus_req after reset", 32'(bus_req), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);

        // R6 software cannot set the NMI flag
        wr(GLB, 32'h2);
        rd(GLB, v);
        chk(v == 0, "R6 software write of 1 to NMI flag", v, 0);
        wr(GLB, 32'h1);

        // R2 R10 sweep of block lengths on both channels
        dptr = 32;
        for (int ch = 0; ch < 2; ch++) begin
            for (int n = 1; n <= 4; n++) begin
                s    = ch * 16 + n;
                base = wcnt;
                setup(ch, s, dptr, n, 1);
                pulse_ext(ch);
                wait_writes(base + n);
                idle(4);
                verify_block(ch, s, dptr, n, "R10 sweep");
                for (int k = 0; k < n; k++) begin
                    chk(wlog[base + k] == 32'((dptr + k) * 4), "R2 write beat address",
                        wlog[base + k], 32'((dptr + k) * 4));
                end
                dptr += n;
            end
        end

        // R3 done flag blocks the channel until cleared
        base = wcnt;
        wr(0, 32'(3 * 4));
        wr(1, 32'(dptr * 4));
        wr(2, 32'd2);
        pulse_ext(0);
        idle(30);
        chk(wcnt == base, "R3 no transfer while done set", 32'(wcnt - base), 0);
        rd(2, v);
        chk(v == 2, "R3 count untouched while done set", v, 2);
        wr(3, 32'h1);
        wait_writes(base + 2);
        idle(4);
        verify_block(0, 3, dptr, 2, "R3 after clear");
        dptr += 2;

        // R5 R6 R7 NMI halt mid-block
        s = 5; d = dptr; base = wcnt;
        setup(0, s, d, 8, 1);
        pulse_ext(0);
        wait_writes(base + 3);
        pulse_nmi();
        idle(20);
        rd(2, v);
        chk(v == 5, "R5 count after NMI halt", v, 5);
        rd(0, v);
        chk(v == 32'((s + 3) * 4), "R5 source after NMI halt", v, 32'((s + 3) * 4));
        rd(1, v);
        chk(v == 32'((d + 3) * 4), "R5 destination after NMI halt", v, 32'((d + 3) * 4));
        rd(3, v);
        chk(v[1] == 1'b0, "R5 no done on NMI halt", v, v & ~32'h2);
        chk(wcnt == base + 3, "R5 no extra transfer", 32'(wcnt - base), 3);
        chk(bus_req == 1'b0, "R5 bus released on NMI", 32'(bus_req), 0);
        pulse_ext(0);
        idle(20);
        chk(wcnt == base + 3, "R7 ext pulse ignored under NMI", 32'(wcnt - base), 3);
        wr(GLB, 32'h1);
        rd(GLB, v);
        chk(v == 32'h3, "R6 flag kept after write without read", v, 32'h3);
        wr(GLB, 32'h1);
        rd(GLB, v);
        chk(v == 32'h1, "R6 flag cleared after read-1 then write-0", v, 32'h1);
        idle(20);
        chk(wcnt == base + 3, "R7 latched request dropped", 32'(wcnt - base), 3);
        pulse_ext(0);
        wait_writes(base + 8);
        idle(4);
        verify_block(0, s, d, 8, "R7 resume on fresh pulse");
        dptr += 8;

        // R9 master enable halt and resume
        s = 10; d = dptr; base = wcnt;
        setup(1, s, d, 6, 1);
        pulse_ext(1);
        wait_writes(base + 2);
        wr(GLB, 32'h0);
        idle(20);
        rd(6, v);
        chk(v == 4, "R9 count after enable clear", v, 4);
        rd(4, v);
        chk(v == 32'((s + 2) * 4), "R9 source kept", v, 32'((s + 2) * 4));
        rd(5, v);
        chk(v == 32'((d + 2) * 4), "R9 destination kept", v, 32'((d + 2) * 4));
        rd(7, v);
        chk(v[1] == 1'b0, "R9 no done on enable halt", v, v & ~32'h2);
        chk(wcnt == base + 2, "R9 no extra transfer", 32'(wcnt - base), 2);
        wr(GLB, 32'h1);
        wait_writes(base + 6);
        idle(4);
        verify_block(1, s, d, 6, "R9 resume without request");
        dptr += 6;

        // R4 fixed priority
        wr(GLB, 32'h0);
        setup(0, 12, dptr, 3, 1);
        setup(1, 20, dptr + 3, 3, 1);
        base = wcnt;
        ext_req = 2'b11;
        idle(1);
        ext_req = 2'b00;
        wr(GLB, 32'h1);
        wait_writes(base + 6);
        idle(4);
        for (int k = 0; k < 6; k++) begin
            chk(wlog[base + k] == 32'((dptr + k) * 4), "R4 channel 0 served first",
                wlog[base + k], 32'((dptr + k) * 4));
        end
        verify_block(0, 12, dptr, 3, "R4 ch0");
        verify_block(1, 20, dptr + 3, 3, "R4 ch1");
        dptr += 6;

        // R10 internal request, R8 block and re-arm
        int_req_en[1] = 1'b1;
        int_req[1]    = 1'b1;
        base = wcnt;
        setup(1, 2, dptr, 3, 5);
        wait_writes(base + 3);
        idle(4);
        verify_block(1, 2, dptr, 3, "R10 internal");
        dptr += 3;

        s = 7; d = dptr; base = wcnt;
        setup(1, s, d, 6, 5);
        wait_writes(base + 2);
        pulse_nmi();
        idle(20);
        rd(6, v);
        chk(v == 4, "R8 count after NMI on internal channel", v, 4);
        rd(GLB, v);
        chk(v == 32'h3, "R6 flag visible before clear", v, 32'h3);
        wr(GLB, 32'h1);
        idle(20);
        chk(wcnt == base + 2, "R8 internal request still blocked", 32'(wcnt - base), 2);
        int_req_en[1] = 1'b0;
        idle(1);
        int_req_en[1] = 1'b1;
        wait_writes(base + 6);
        idle(4);
        verify_block(1, s, d, 6, "R8 after enable toggle");
        int_req = '0;

        summary();
        $finish;
    end

endmodule